// File: doc/BRIEF.md
# Dilated Crossbar Circuit Router

This block is a circuit-switched switching element with eight input ports and eight output ports. Each port has a forward channel and a reverse channel. Each channel is nine bits wide: a data byte plus a framing bit. A sender opens a transmission by raising the framing bit. The first byte is a header, and its top two bits request one of four output directions. If the router finds a free output in that direction, the transmission is connected and every later word is passed through, delayed by one register stage. If no output is free, the transmission is discarded until it closes. When the framing bit drops, the router returns a single status word to the sender on its reverse channel, so that the sender can decide whether to retry.

The `split_mode` input selects one of two arrangements. In the wide arrangement, all eight inputs are equivalent and each direction has a pair of outputs (2d, 2d+1). When both outputs of a pair are free, a free-running pseudo-random source chooses between them. In the split arrangement, the switch acts as two independent four-input crossbars. Inputs 0..3 reach only output 0+d and inputs 4..7 reach only output 4+d. Inputs that request in the same cycle are served in a rotating order. An open connection can be turned around by a dedicated forward word, after which the destination's reverse channel is relayed back to the source. `split_mode` may only change while no transmission is open.

Top module: `xr_router`

## Requirements
- R1: After reset, every forward output and every reverse output is all zero.
- R2: A header word (framing bit rising at an idle input) requests direction d = data[7:6]. In the wide arrangement it appears unchanged, one cycle later, on exactly one of outputs 2d and 2d+1, and on no other output.
- R3: While the connection is open, each forward word appears on the granted output one cycle after it is presented. The word that closes the transmission (framing bit low) is also forwarded. The output is then zero and free from the following cycle.
- R4: In the wide arrangement, if one output of the requested pair is held by another connection, a new request in that direction is given the other output.
- R5: A request that finds no free output is blocked. None of its words appear on any output.
- R6: One cycle after the closing word, the sender's reverse output carries framing bit 1 with data 0x01 if the transmission was connected, or 0x00 if it was blocked. In the next cycle the reverse output is zero.
- R7: A forward word with framing bit 1 and data 0xFF on an open connection is forwarded and turns the connection around. From the next cycle onward, the granted output's reverse input appears on the sender's reverse output one cycle later.
- R8: Before a turnaround, the reverse output of an open connection stays zero, whatever its output's reverse input carries.
- R9: In the split arrangement, input i requesting direction d is connected only to output 4*(i/4)+d. The two halves do not interfere.
- R10: When more inputs request a direction in the same cycle than there are free outputs, exactly as many requests are granted as there are free outputs, and the rest are blocked.
- R11: Across repeated wide-arrangement requests with both outputs free, both outputs of every pair are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_mode | input | 1 | 0: one 8-input switch with dilation two; 1: two 4-input switches with dilation one |
| fwd_in | input | 72 | Forward words arriving at inputs, port i at bits [9i+8:9i], framing bit at 9i+8 |
| fwd_out | output | 72 | Forward words leaving outputs, same layout |
| rev_in | input | 72 | Reverse words arriving at outputs from destinations |
| rev_out | output | 72 | Reverse words returned to senders (status and turned-around data) |

## Verification
Forward words, including headers and the closing word, are due on the output one cycle after they are presented. The status word is due one cycle after the closing word. Once the 0xFF turn word has been registered, each reverse-input word reaches the sender one cycle later. The bench drives every input two nanoseconds after a rising edge and reads the outputs at the same point after the next edge, so each check lands exactly on the cycle named above. Where the pseudo-random choice leaves the output unknown, the bench locates the word within the legal pair and then requires every other output to be zero.

// File: rtl/xr_pkg.sv
package xr_pkg;

    // Per-input connection state
    typedef enum logic [1:0] {
        P_IDLE = 2'd0,
        P_FWD  = 2'd1,
        P_REV  = 2'd2,
        P_BLK  = 2'd3
    } pstate_e;

endpackage

// File: rtl/xr_lfsr16.sv
module xr_lfsr16 #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] q_o
);

    logic [15:0] lfsr_d, lfsr_q;

    // x^16 + x^14 + x^13 + x^11, Fibonacci form, advances every cycle
    always_comb begin
        lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign q_o = lfsr_q;

endmodule

// File: rtl/xr_alloc.sv
module xr_alloc #(
    parameter  int NP = 8,
    localparam int SW = $clog2(NP)
) (
    input  logic             split_i,
    input  logic [NP-1:0]    req_i,
    input  logic [2*NP-1:0]  dir_i,
    input  logic [NP-1:0]    busy_i,
    input  logic [SW-1:0]    rr_i,
    input  logic [NP-1:0]    rnd_i,
    output logic [NP-1:0]    grant_o,
    output logic [NP*SW-1:0] gsel_o
);

    localparam int HALF = NP / 2;
    localparam int DIL  = NP / 4;

    // Requests are visited in rotating order; each claim is seen by later ones
    always_comb begin
        logic [NP-1:0] taken;
        int idx, c0, c;
        logic f0, f1;
        taken   = busy_i;
        grant_o = '0;
        gsel_o  = '0;
        idx = 0; c0 = 0; c = 0; f0 = 1'b0; f1 = 1'b0;
        for (int k = 0; k < NP; k++) begin
            idx = (int'(rr_i) + k) % NP;
            if (req_i[idx]) begin
                if (split_i) begin
                    c0 = ((idx >= HALF) ? HALF : 0) + int'(dir_i[2*idx +: 2]);
                    if (!taken[c0]) begin
                        grant_o[idx]         = 1'b1;
                        gsel_o[idx*SW +: SW] = SW'(c0);
                        taken[c0]            = 1'b1;
                    end
                end else begin
                    c0 = DIL * int'(dir_i[2*idx +: 2]);
                    f0 = !taken[c0];
                    f1 = !taken[c0+1];
                    if (f0 && f1)  c = c0 + int'(rnd_i[idx]);
                    else if (f0)   c = c0;
                    else           c = c0 + 1;
                    if (f0 || f1) begin
                        grant_o[idx]         = 1'b1;
                        gsel_o[idx*SW +: SW] = SW'(c);
                        taken[c]             = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/xr_xbar.sv
module xr_xbar #(
    parameter  int NP = 8,
    parameter  int CW = 9,
    localparam int SW = $clog2(NP)
) (
    input  logic [NP*CW-1:0] src_i,
    input  logic [NP-1:0]    en_i,
    input  logic [NP*SW-1:0] sel_i,
    output logic [NP*CW-1:0] dst_o
);

    for (genvar o = 0; o < NP; o++) begin : g_out
        always_comb begin
            dst_o[o*CW +: CW] = '0;
            for (int i = 0; i < NP; i++) begin
                if (en_i[i] && (sel_i[i*SW +: SW] == SW'(o)))
                    dst_o[o*CW +: CW] = src_i[i*CW +: CW];
            end
        end
    end

endmodule

// File: rtl/xr_router.sv
module xr_router
    import xr_pkg::*;
#(
    parameter int NP = 8,
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                split_mode,
    input  logic [NP*(DW+1)-1:0] fwd_in,
    output logic [NP*(DW+1)-1:0] fwd_out,
    input  logic [NP*(DW+1)-1:0] rev_in,
    output logic [NP*(DW+1)-1:0] rev_out
);

    localparam int CW = DW + 1;
    localparam int SW = $clog2(NP);
    localparam logic [DW-1:0] TURN_WORD = '1;
    localparam logic [DW-1:0] STAT_OK   = DW'(1);
    localparam logic [DW-1:0] STAT_BLK  = '0;

    typedef struct packed {
        pstate_e [NP-1:0]          ps;
        logic    [NP-1:0][SW-1:0]  sel;
        logic    [SW-1:0]          rr;
        logic    [NP*CW-1:0]       fo;
        logic    [NP*CW-1:0]       ro;
    } st_t;

    st_t st_d, st_q;

    logic [15:0]      lfsr;
    logic [NP-1:0]    rnd, busy, req, grant, drive;
    logic [2*NP-1:0]  dir;
    logic [NP*SW-1:0] gsel, dsel;
    logic [NP*CW-1:0] froute;

    xr_lfsr16 #(.SEED(16'hACE1)) lfsr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .q_o  (lfsr)
    );

    assign rnd = lfsr[NP-1:0] ^ lfsr[15 -: NP];

    always_comb begin
        busy = '0;
        for (int i = 0; i < NP; i++) begin
            req[i]         = (st_q.ps[i] == P_IDLE) && fwd_in[i*CW + DW];
            dir[2*i +: 2]  = fwd_in[i*CW + DW - 1 -: 2];
            if (st_q.ps[i] == P_FWD || st_q.ps[i] == P_REV) busy[st_q.sel[i]] = 1'b1;
        end
    end

    xr_alloc #(.NP(NP)) alloc_i (
        .split_i(split_mode),
        .req_i  (req),
        .dir_i  (dir),
        .busy_i (busy),
        .rr_i   (st_q.rr),
        .rnd_i  (rnd),
        .grant_o(grant),
        .gsel_o (gsel)
    );

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            drive[i]          = grant[i] || (st_q.ps[i] == P_FWD) || (st_q.ps[i] == P_REV);
            dsel[i*SW +: SW]  = grant[i] ? gsel[i*SW +: SW] : st_q.sel[i];
        end
    end

    xr_xbar #(.NP(NP), .CW(CW)) xbar_i (
        .src_i(fwd_in),
        .en_i (drive),
        .sel_i(dsel),
        .dst_o(froute)
    );

    always_comb begin
        logic [CW-1:0] w;
        st_d    = st_q;
        st_d.rr = st_q.rr + 1'b1;
        st_d.fo = froute;
        st_d.ro = '0;
        w       = '0;
        for (int i = 0; i < NP; i++) begin
            w = fwd_in[i*CW +: CW];
            case (st_q.ps[i])
                P_IDLE: begin
                    if (w[DW]) begin
                        if (grant[i]) begin
                            st_d.ps[i]  = P_FWD;
                            st_d.sel[i] = gsel[i*SW +: SW];
                        end else begin
                            st_d.ps[i]  = P_BLK;
                        end
                    end
                end
                P_FWD: begin
                    if (!w[DW]) begin
                        st_d.ps[i]          = P_IDLE;
                        st_d.ro[i*CW +: CW] = {1'b1, STAT_OK};
                    end else if (w[DW-1:0] == TURN_WORD) begin
                        st_d.ps[i]          = P_REV;
                    end
                end
                P_REV: begin
                    if (!w[DW]) begin
                        st_d.ps[i]          = P_IDLE;
                        st_d.ro[i*CW +: CW] = {1'b1, STAT_OK};
                    end else begin
                        st_d.ro[i*CW +: CW] = rev_in[int'(st_q.sel[i])*CW +: CW];
                    end
                end
                default: begin
                    if (!w[DW]) begin
                        st_d.ps[i]          = P_IDLE;
                        st_d.ro[i*CW +: CW] = {1'b1, STAT_BLK};
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fwd_out = st_q.fo;
    assign rev_out = st_q.ro;

endmodule

// File: rtl/xr_router_chk.sv
module xr_router_chk #(
    parameter  int NP = 8,
    parameter  int DW = 8,
    localparam int CW = DW + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             split_mode,
    input logic [NP*CW-1:0] fwd_in,
    input logic [NP*CW-1:0] fwd_out,
    input logic [NP*CW-1:0] rev_out
);

    localparam int H = NP / 2;

    logic [NP-1:0] in_ctl, out_ctl, rev_ctl;
    logic [1:0]    age;
    logic          unused_bits;

    for (genvar i = 0; i < NP; i++) begin : g_ctl
        assign in_ctl[i]  = fwd_in[i*CW + DW];
        assign out_ctl[i] = fwd_out[i*CW + DW];
        assign rev_ctl[i] = rev_out[i*CW + DW];
    end

    assign unused_bits = ^{fwd_in, fwd_out};

    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R3: every active output word stems from an input word of the previous cycle
    p_fanout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) |-> ($countones(out_ctl) <= $countones($past(in_ctl))));

    for (genvar g = 0; g < 2; g++) begin : g_half
        // R9: in the split arrangement a half's outputs are fed only by its own inputs
        p_half_isolation_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ((age != 2'd0) && split_mode && $past(split_mode)) |->
            ($countones(out_ctl[g*H +: H]) <= $countones($past(in_ctl[g*H +: H]))));
    end

    for (genvar i = 0; i < NP; i++) begin : g_rev
        // R6: a reverse word following a low framing bit can only be a status code
        p_status_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ((age != 2'd0) && !$past(in_ctl[i]) && rev_ctl[i]) |->
            (rev_out[i*CW +: DW] inside {DW'(0), DW'(1)}));
        // R6: two quiet input cycles leave the reverse output silent
        p_rev_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ((age >= 2'd2) && !$past(in_ctl[i]) && !$past(in_ctl[i], 2)) |->
            (rev_out[i*CW +: CW] == '0));
    end

endmodule

bind xr_router xr_router_chk #(.NP(NP), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .split_mode(split_mode),
    .fwd_in    (fwd_in),
    .fwd_out   (fwd_out),
    .rev_out   (rev_out)
);

// File: tb/xr_router_tb_top.sv
module xr_router_tb_top;

    localparam int NP = 8;
    localparam int DW = 8;
    localparam int CW = DW + 1;
    localparam int VW = NP * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          split = 1'b0;
    logic [VW-1:0] fwd_in = '0;
    logic [VW-1:0] rev_in = '0;
    logic [VW-1:0] fwd_out, rev_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit used [NP];

    always #10 clk = ~clk;

    xr_router #(.NP(NP), .DW(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .split_mode(split),
        .fwd_in    (fwd_in),
        .fwd_out   (fwd_out),
        .rev_in    (rev_in),
        .rev_out   (rev_out)
    );

    task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] fo(input int o);
        return fwd_out[o*CW +: CW];
    endfunction

    function automatic logic [CW-1:0] ro(input int i);
        return rev_out[i*CW +: CW];
    endfunction

    function automatic logic [VW-1:0] place(input int o, input logic [CW-1:0] w);
        logic [VW-1:0] v;
        v = '0;
        v[o*CW +: CW] = w;
        return v;
    endfunction

    function automatic bit on_any(input logic [CW-1:0] w);
        for (int o = 0; o < NP; o++) if (fo(o) == w) return 1'b1;
        return 1'b0;
    endfunction

    task automatic set_in(input int i, input logic [CW-1:0] w);
        fwd_in[i*CW +: CW] = w;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        logic [CW-1:0] hdr, pay, h;
        int o, o1, o2, b, cnt;

        // R1: reset state
        repeat (3) tick();
        rst_n = 1'b1;
        chk(fwd_out == '0, "R1 fwd_out", fwd_out, '0);
        chk(rev_out == '0, "R1 rev_out", rev_out, '0);

        // Wide arrangement sweep: R2, R3, R6, R11
        for (int rnd = 0; rnd < 4; rnd++) begin
            for (int i = 0; i < NP; i++) begin
                for (int d = 0; d < 4; d++) begin
                    hdr = {1'b1, 2'(d), 3'b000, 3'(i)};
                    pay = {1'b1, 8'h5A ^ 8'(i)};
                    set_in(i, hdr);
                    tick();
                    o = -1;
                    if (fo(2*d) == hdr) o = 2*d;
                    if (fo(2*d+1) == hdr) o = 2*d + 1;
                    if (o < 0) o = 2*d;
                    chk(fwd_out == place(o, hdr), "R2 header route", fwd_out, place(o, hdr));
                    used[o] = 1'b1;
                    set_in(i, pay);
                    tick();
                    chk(fo(o) == pay, "R3 payload", fo(o), pay);
                    chk(ro(i) == '0, "R8 no reverse before turn", ro(i), '0);
                    set_in(i, {1'b0, 8'h3C});
                    tick();
                    chk(fo(o) == {1'b0, 8'h3C}, "R3 close forwarded", fo(o), {1'b0, 8'h3C});
                    chk(ro(i) == {1'b1, 8'h01}, "R6 status connected", ro(i), {1'b1, 8'h01});
                    set_in(i, '0);
                    tick();
                    chk(fwd_out == '0, "R3 released", fwd_out, '0);
                    chk(ro(i) == '0, "R6 status one cycle", ro(i), '0);
                end
            end
        end
        for (int d = 0; d < 4; d++)
            chk(used[2*d] && used[2*d+1], "R11 both outputs used", VW'({used[2*d], used[2*d+1]}), VW'(2'b11));

        // R10 and R5: three simultaneous requests for one pair
        h = {1'b1, 2'b01, 6'd0};
        for (int i = 0; i < 3; i++) set_in(i, h);
        tick();
        chk(fo(2) == h && fo(3) == h, "R10 two granted", fwd_out, place(2, h) | place(3, h));
        for (int i = 0; i < 3; i++) set_in(i, {1'b1, 8'h10 + 8'(i)});
        tick();
        b = -1;
        cnt = 0;
        for (int i = 0; i < 3; i++) begin
            if (on_any({1'b1, 8'h10 + 8'(i)})) cnt++;
            else b = i;
        end
        chk(cnt == 2, "R10 exactly two carried", VW'(cnt), VW'(2));
        chk(b >= 0, "R5 blocked words absent", VW'(cnt), VW'(2));
        if (b < 0) b = 2;
        for (int i = 0; i < 3; i++) set_in(i, '0);
        tick();
        for (int i = 0; i < 3; i++)
            chk(ro(i) == ((i == b) ? {1'b1, 8'h00} : {1'b1, 8'h01}), "R6 status after contention",
                ro(i), (i == b) ? {1'b1, 8'h00} : {1'b1, 8'h01});
        tick();

        // R4: second request takes the other output of the pair; R5 third is blocked
        h = {1'b1, 2'b10, 6'd0};
        set_in(3, h);
        tick();
        o1 = (fo(4) == h) ? 4 : 5;
        set_in(3, {1'b1, 8'h33});
        set_in(4, h);
        tick();
        o2 = (o1 == 4) ? 5 : 4;
        chk(fo(o2) == h, "R4 other output", fo(o2), h);
        chk(fo(o1) == {1'b1, 8'h33}, "R3 first still open", fo(o1), {1'b1, 8'h33});
        set_in(4, {1'b1, 8'h44});
        set_in(5, h);
        tick();
        set_in(5, {1'b1, 8'hC5});
        tick();
        chk(!on_any({1'b1, 8'hC5}), "R5 blocked payload", fwd_out, '0);
        for (int i = 3; i < 6; i++) set_in(i, '0);
        tick();
        chk(ro(5) == {1'b1, 8'h00}, "R6 blocked status", ro(5), {1'b1, 8'h00});
        chk(ro(3) == {1'b1, 8'h01}, "R6 connected status", ro(3), {1'b1, 8'h01});
        tick();

        // R7 and R8: turnaround
        h = {1'b1, 2'b11, 6'd1};
        set_in(6, h);
        tick();
        o = (fo(7) == h) ? 7 : 6;
        rev_in[o*CW +: CW] = {1'b1, 8'hA5};
        set_in(6, {1'b1, 8'h12});
        tick();
        chk(ro(6) == '0, "R8 reverse ignored before turn", ro(6), '0);
        set_in(6, {1'b1, 8'hFF});
        tick();
        chk(fo(o) == {1'b1, 8'hFF}, "R7 turn word forwarded", fo(o), {1'b1, 8'hFF});
        chk(ro(6) == '0, "R8 reverse still quiet", ro(6), '0);
        set_in(6, {1'b1, 8'h00});
        rev_in[o*CW +: CW] = {1'b1, 8'h77};
        tick();
        chk(ro(6) == {1'b1, 8'h77}, "R7 reverse relayed", ro(6), {1'b1, 8'h77});
        rev_in[o*CW +: CW] = {1'b1, 8'h33};
        tick();
        chk(ro(6) == {1'b1, 8'h33}, "R7 reverse follows", ro(6), {1'b1, 8'h33});
        rev_in = '0;
        set_in(6, '0);
        tick();
        chk(ro(6) == {1'b1, 8'h01}, "R6 status after turn", ro(6), {1'b1, 8'h01});
        tick();

        // R9: split arrangement sweep
        split = 1'b1;
        tick();
        for (int i = 0; i < NP; i++) begin
            for (int d = 0; d < 4; d++) begin
                hdr = {1'b1, 2'(d), 3'b101, 3'(i)};
                o = (i / 4) * 4 + d;
                set_in(i, hdr);
                tick();
                chk(fwd_out == place(o, hdr), "R9 split route", fwd_out, place(o, hdr));
                set_in(i, '0);
                tick();
                chk(ro(i) == {1'b1, 8'h01}, "R6 split status", ro(i), {1'b1, 8'h01});
                tick();
            end
        end

        // R9 halves independent, R5 dilation one blocks
        h = {1'b1, 2'b10, 6'd2};
        set_in(0, h);
        set_in(4, h);
        tick();
        chk(fo(2) == h && fo(6) == h, "R9 halves independent", fwd_out, place(2, h) | place(6, h));
        set_in(0, {1'b1, 8'h01});
        set_in(4, {1'b1, 8'h04});
        set_in(1, h);
        tick();
        set_in(1, {1'b1, 8'hE1});
        tick();
        chk(!on_any({1'b1, 8'hE1}), "R5 split blocked payload", fwd_out, '0);
        for (int i = 0; i < NP; i++) set_in(i, '0);
        tick();
        chk(ro(1) == {1'b1, 8'h00}, "R5 split blocked status", ro(1), {1'b1, 8'h00});
        chk(ro(0) == {1'b1, 8'h01}, "R6 split connected status", ro(0), {1'b1, 8'h01});
        tick();

        done = 1'b1;
        summary();
    end

endmodule